// File: doc/BRIEF.md
# Per-Mode XLEN Control Unit

This block holds the two width-selector fields of the machine status register that set the register width of supervisor mode and user mode. The core is built as 32, 64 or 128 bits wide. Software writes the fields through a small write port, and the block accepts only encodings that this build supports. The read port always returns the legal values. The block also reports the width of the current privilege level, chosen combinationally from the privilege input.

The same width drives a datapath adapter in the block. Source operands are masked down to the active width, so that bits above it play no part. A result from a narrower mode is sign-extended from its top active bit to fill the full register. Build parameters choose which lower modes exist and whether each selector is variable or fixed. A fixed supervisor field follows the machine width. A fixed user field follows either the machine width or the supervisor field.

Top module: `xlen_ctrl`

## Requirements
- R1: After reset, a selector whose mode exists on a 64- or 128-bit build reads the machine width encoding (1 = 32, 2 = 64, 3 = 128 bits).
- R2: On a 32-bit build both selectors read 0, and every privilege level runs at width encoding 1.
- R3: A selector whose mode is absent reads 0 and ignores writes.
- R4: The read/write word carries the user selector in bits 1:0 and the supervisor selector in bits 3:2. A write with `fld_we` high and a value from 1 to the machine encoding updates a variable selector, and the new value is visible from the next cycle on.
- R5: A written value of 0, or one above the machine encoding, leaves that selector unchanged.
- R6: With `SXL_FIXED` set, the supervisor selector always reads the machine encoding and ignores writes.
- R7: `UXL_MODE` 1 pins the user selector to the machine encoding. `UXL_MODE` 2 makes it track the supervisor selector, or the machine encoding when supervisor mode is absent.
- R8: `cur_xl` is the machine encoding for privilege 3 (machine) and for the reserved value 2. For privilege 1 (supervisor) and privilege 0 (user) it is that mode's selector, or the machine encoding if the mode is absent.
- R9: `src_a_adj` and `src_b_adj` equal the raw operands with every bit at or above the active width cleared.
- R10: `res_adj` equals `res_raw` below the active width, and every bit above it copies bit (width-1).
- R11: In a cycle where a write is presented, the adapter still works at the width held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fld_we | input | 1 | Selector write enable |
| fld_wdata | input | 4 | Write value: [3:2] supervisor, [1:0] user |
| fld_rdata | output | 4 | Legal selector values, same layout |
| priv_mode | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| cur_xl | output | 2 | Width encoding of the current privilege |
| src_a_raw | input | W | Raw source operand A |
| src_b_raw | input | W | Raw source operand B |
| src_a_adj | output | W | Operand A masked to the active width |
| src_b_adj | output | W | Operand B masked to the active width |
| res_raw | input | W | Raw result |
| res_adj | output | W | Result sign-extended from the active width |

## Verification
A selector write and operand adaptation can fall in the same cycle. The adapter must then still use the width held before the write. The bench provokes this with table rows that present a write together with a user-mode or supervisor-mode operand and a result whose sign bit is set. It judges the adapted outputs against the old width before the clock edge, then checks the next row against the new width. Extra instances built for a 32-bit core, an absent supervisor mode and fixed selectors are driven with the same writes and checked after a fresh reset.

// File: rtl/xlen_pkg.sv
package xlen_pkg;

    typedef logic [1:0] xl_t;

    localparam xl_t XL_NONE = 2'd0;
    localparam xl_t XL_32   = 2'd1;
    localparam xl_t XL_64   = 2'd2;
    localparam xl_t XL_128  = 2'd3;

    typedef enum logic [1:0] {
        PRV_USER = 2'd0,
        PRV_SUP  = 2'd1,
        PRV_RSV  = 2'd2,
        PRV_MACH = 2'd3
    } prv_e;

    typedef struct packed {
        xl_t sup;
        xl_t usr;
    } xl_state_t;

    function automatic int xl_width(xl_t enc);
        case (enc)
            XL_64:   return 64;
            XL_128:  return 128;
            default: return 32;
        endcase
    endfunction

endpackage

// File: rtl/xlen_legal.sv
module xlen_legal
    import xlen_pkg::*;
#(
    parameter int MENC    = 2,
    parameter bit PRESENT = 1'b1,
    parameter bit FIXED   = 1'b0
) (
    input  xl_t  cur,
    input  logic we,
    input  xl_t  wval,
    input  xl_t  fix_val,
    output xl_t  nxt
);
    localparam xl_t M_XL = xl_t'(MENC);

    generate
        if (!PRESENT || MENC == 1) begin : g_absent
            assign nxt = XL_NONE;
        end else if (FIXED) begin : g_fixed
            assign nxt = fix_val;
        end else begin : g_warl
            logic ok;
            always_comb begin
                ok  = (wval != XL_NONE) && (wval <= M_XL);
                nxt = (we && ok) ? wval : cur;
            end
        end
    endgenerate

    logic unused_in;
    assign unused_in = ^{cur, we, wval, fix_val};

endmodule

// File: rtl/xlen_adapt.sv
module xlen_adapt
    import xlen_pkg::*;
#(
    parameter int W = 64
) (
    input  xl_t          eff,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic [W-1:0] r_in,
    output logic [W-1:0] a_out,
    output logic [W-1:0] b_out,
    output logic [W-1:0] r_out
);
    always_comb begin
        int  w;
        logic sgn;
        w = xl_width(eff);
        if (w > W) w = W;
        sgn = r_in[w-1];
        for (int i = 0; i < W; i++) begin
            a_out[i] = (i < w) ? a_in[i] : 1'b0;
            b_out[i] = (i < w) ? b_in[i] : 1'b0;
            r_out[i] = (i < w) ? r_in[i] : sgn;
        end
    end
endmodule

// File: rtl/xlen_ctrl.sv
module xlen_ctrl
    import xlen_pkg::*;
#(
    parameter int MENC      = 2,
    parameter bit HAS_S     = 1'b1,
    parameter bit HAS_U     = 1'b1,
    parameter bit SXL_FIXED = 1'b0,
    parameter int UXL_MODE  = 0,
    localparam int W        = 32 << (MENC - 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fld_we,
    input  logic [3:0]   fld_wdata,
    output logic [3:0]   fld_rdata,
    input  logic [1:0]   priv_mode,
    output logic [1:0]   cur_xl,
    input  logic [W-1:0] src_a_raw,
    input  logic [W-1:0] src_b_raw,
    output logic [W-1:0] src_a_adj,
    output logic [W-1:0] src_b_adj,
    input  logic [W-1:0] res_raw,
    output logic [W-1:0] res_adj
);
    localparam xl_t M_XL   = xl_t'(MENC);
    localparam bit  S_LIVE = HAS_S && (MENC > 1);
    localparam bit  U_LIVE = HAS_U && (MENC > 1);
    localparam xl_state_t RST_VAL = '{
        sup: S_LIVE ? M_XL : XL_NONE,
        usr: U_LIVE ? M_XL : XL_NONE
    };

    xl_state_t st_d, st_q;
    xl_t       s_nxt, u_nxt, u_fix, eff;

    xlen_legal #(.MENC(MENC), .PRESENT(HAS_S), .FIXED(SXL_FIXED)) i_sup_legal (
        .cur(st_q.sup), .we(fld_we), .wval(fld_wdata[3:2]),
        .fix_val(M_XL), .nxt(s_nxt)
    );

    generate
        if (UXL_MODE == 2 && HAS_S) begin : g_ufollow_s
            assign u_fix = s_nxt;
        end else begin : g_ufollow_m
            assign u_fix = M_XL;
        end
    endgenerate

    xlen_legal #(.MENC(MENC), .PRESENT(HAS_U), .FIXED(UXL_MODE != 0)) i_usr_legal (
        .cur(st_q.usr), .we(fld_we), .wval(fld_wdata[1:0]),
        .fix_val(u_fix), .nxt(u_nxt)
    );

    always_comb begin
        st_d     = st_q;
        st_d.sup = s_nxt;
        st_d.usr = u_nxt;
        case (prv_e'(priv_mode))
            PRV_SUP:  eff = S_LIVE ? st_q.sup : M_XL;
            PRV_USER: eff = U_LIVE ? st_q.usr : M_XL;
            default:  eff = M_XL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RST_VAL;
        else        st_q <= st_d;
    end

    assign fld_rdata = {st_q.sup, st_q.usr};
    assign cur_xl    = eff;

    xlen_adapt #(.W(W)) i_adapt (
        .eff(eff), .a_in(src_a_raw), .b_in(src_b_raw), .r_in(res_raw),
        .a_out(src_a_adj), .b_out(src_b_adj), .r_out(res_adj)
    );

endmodule

// File: rtl/xlen_ctrl_chk.sv
module xlen_ctrl_chk
    import xlen_pkg::*;
#(
    parameter int MENC      = 2,
    parameter bit HAS_S     = 1'b1,
    parameter bit SXL_FIXED = 1'b0,
    parameter int UXL_MODE  = 0,
    parameter int W         = 64
) (
    input logic         clk,
    input logic         rst_n,
    input logic         fld_we,
    input logic [3:0]   fld_wdata,
    input logic [3:0]   fld_rdata,
    input logic [1:0]   priv_mode,
    input logic [1:0]   cur_xl,
    input logic [W-1:0] src_a_adj,
    input logic [W-1:0] res_raw,
    input logic [W-1:0] res_adj
);
    localparam xl_t M_XL = xl_t'(MENC);
    int cw;
    always_comb begin
        cw = xl_width(cur_xl);
        if (cw > W) cw = W;
    end

    logic s_bad, u_bad, s_good;
    assign s_bad  = (fld_wdata[3:2] == 2'd0) || (fld_wdata[3:2] > M_XL);
    assign u_bad  = (fld_wdata[1:0] == 2'd0) || (fld_wdata[1:0] > M_XL);
    assign s_good = !s_bad && HAS_S && !SXL_FIXED && (MENC > 1);

    assert_field_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fld_rdata[3:2] <= M_XL && fld_rdata[1:0] <= M_XL);

    assert_sup_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fld_we && s_bad) |=> $stable(fld_rdata[3:2]));

    assert_usr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fld_we && u_bad && UXL_MODE != 2) |=> $stable(fld_rdata[1:0]));

    assert_sup_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fld_we && s_good) |=> (fld_rdata[3:2] == $past(fld_wdata[3:2])));

    assert_mach_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
        priv_mode[1] |-> (cur_xl == M_XL));

    assert_narrow32_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (MENC == 1) |-> (fld_rdata == 4'd0 && cur_xl == XL_32));

    assert_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (src_a_adj >> cw) == '0);

    assert_sext_R10: assert property (@(posedge clk) disable iff (!rst_n)
        res_adj[W-1] == res_raw[cw-1]);

endmodule

bind xlen_ctrl xlen_ctrl_chk #(
    .MENC(MENC), .HAS_S(HAS_S), .SXL_FIXED(SXL_FIXED),
    .UXL_MODE(UXL_MODE), .W(W)
) i_xlen_ctrl_chk (
    .clk(clk), .rst_n(rst_n), .fld_we(fld_we), .fld_wdata(fld_wdata),
    .fld_rdata(fld_rdata), .priv_mode(priv_mode), .cur_xl(cur_xl),
    .src_a_adj(src_a_adj), .res_raw(res_raw), .res_adj(res_adj)
);

// File: tb/test_xlen_ctrl.sv
`timescale 1ns/1ps
module test_xlen_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [3:0]  wdata = 4'd0;
    logic [1:0]  priv = 2'd3;
    logic [63:0] opa = '0, opb = '0, res = '0;
    logic [63:0] opa_o, opb_o, res_o;
    logic [3:0]  rd, rd32, rdns, rdfx;
    logic [1:0]  eff, eff32, effns, efffx;
    logic [31:0] x32a, x32b, x32r;
    logic [127:0] xnsa, xnsb, xnsr, xfxa, xfxb, xfxr;
    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    xlen_ctrl i_xlen_ctrl (
        .clk(clk), .rst_n(rst_n), .fld_we(we), .fld_wdata(wdata), .fld_rdata(rd),
        .priv_mode(priv), .cur_xl(eff), .src_a_raw(opa), .src_b_raw(opb),
        .src_a_adj(opa_o), .src_b_adj(opb_o), .res_raw(res), .res_adj(res_o));

    xlen_ctrl #(.MENC(1)) i_xlen_ctrl_rv32 (
        .clk(clk), .rst_n(rst_n), .fld_we(we), .fld_wdata(wdata), .fld_rdata(rd32),
        .priv_mode(priv), .cur_xl(eff32), .src_a_raw(32'h0), .src_b_raw(32'h0),
        .src_a_adj(x32a), .src_b_adj(x32b), .res_raw(32'h0), .res_adj(x32r));

    xlen_ctrl #(.MENC(3), .HAS_S(1'b0)) i_xlen_ctrl_nos (
        .clk(clk), .rst_n(rst_n), .fld_we(we), .fld_wdata(wdata), .fld_rdata(rdns),
        .priv_mode(priv), .cur_xl(effns), .src_a_raw(128'h0), .src_b_raw(128'h0),
        .src_a_adj(xnsa), .src_b_adj(xnsb), .res_raw(128'h0), .res_adj(xnsr));

    xlen_ctrl #(.MENC(3), .SXL_FIXED(1'b1), .UXL_MODE(2)) i_xlen_ctrl_fix (
        .clk(clk), .rst_n(rst_n), .fld_we(we), .fld_wdata(wdata), .fld_rdata(rdfx),
        .priv_mode(priv), .cur_xl(efffx), .src_a_raw(128'h0), .src_b_raw(128'h0),
        .src_a_adj(xfxa), .src_b_adj(xfxb), .res_raw(128'h0), .res_adj(xfxr));

    typedef struct packed {
        logic        we;
        logic [3:0]  wd;
        logic [1:0]  pr;
        logic [3:0]  exp_rd;
        logic [1:0]  exp_eff;
        logic [63:0] op;
        logic [63:0] rs;
    } vec_t;

    // Expected values are those seen before the row's write lands (R11).
    localparam vec_t TBL [0:8] = '{
        '{1'b1, 4'b0101, 2'd3, 4'b1010, 2'd2, 64'hF0F0_1234_8765_4321, 64'h0000_0000_8000_0001},
        '{1'b1, 4'b1100, 2'd1, 4'b0101, 2'd1, 64'hDEAD_BEEF_CAFE_F00D, 64'h1234_5678_8000_0000},
        '{1'b1, 4'b1001, 2'd0, 4'b0101, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_7FFF_FFFF},
        '{1'b0, 4'b0000, 2'd1, 4'b1001, 2'd2, 64'h8000_0000_0000_0001, 64'h8000_0000_0000_0000},
        '{1'b0, 4'b1111, 2'd0, 4'b1001, 2'd1, 64'h0123_4567_89AB_CDEF, 64'hFFFF_0000_FFFF_0000},
        '{1'b1, 4'b0110, 2'd0, 4'b1001, 2'd1, 64'hAAAA_5555_AAAA_5555, 64'h0000_0001_8000_0002},
        '{1'b0, 4'b0000, 2'd0, 4'b0110, 2'd2, 64'h5555_AAAA_5555_AAAA, 64'h7000_0000_8000_0000},
        '{1'b0, 4'b0000, 2'd1, 4'b0110, 2'd1, 64'hCCCC_3333_CCCC_3333, 64'h0000_0000_FFFF_FFFE},
        '{1'b0, 4'b0000, 2'd2, 4'b0110, 2'd2, 64'h1111_2222_3333_4444, 64'h0000_0000_8000_0000}
    };

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_mask(input logic [1:0] e, input logic [63:0] v);
        return (e == 2'd1) ? {32'h0, v[31:0]} : v;
    endfunction

    function automatic logic [63:0] ref_sext(input logic [1:0] e, input logic [63:0] v);
        return (e == 2'd1) ? {{32{v[31]}}, v[31:0]} : v;
    endfunction

    task automatic put(input logic w, input logic [3:0] d, input logic [1:0] p);
        @(negedge clk);
        we = w; wdata = d; priv = p;
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #1000000;
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk("R1 reset main fields", rd, 4'b1010);
        chk("R2 reset rv32 fields", rd32, 4'b0000);

        // Table: writes and adaptation in the same cycle (R4 R5 R8 R9 R10 R11)
        for (int i = 0; i < 9; i++) begin
            @(negedge clk);
            we = TBL[i].we; wdata = TBL[i].wd; priv = TBL[i].pr;
            opa = TBL[i].op; opb = ~TBL[i].op; res = TBL[i].rs;
            #1;
            chk($sformatf("R4 R5 row %0d rdata", i), rd, TBL[i].exp_rd);
            chk($sformatf("R8 R11 row %0d cur_xl", i), eff, TBL[i].exp_eff);
            chk($sformatf("R9 row %0d opA", i), opa_o, ref_mask(TBL[i].exp_eff, TBL[i].op));
            chk($sformatf("R9 row %0d opB", i), opb_o, ref_mask(TBL[i].exp_eff, ~TBL[i].op));
            chk($sformatf("R10 row %0d result", i), res_o, ref_sext(TBL[i].exp_eff, TBL[i].rs));
        end

        // Directed tests on a fresh reset
        @(negedge clk); we = 1'b0; rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; priv = 2'd3;
        #1;
        chk("R3 nos reset S absent, U at M", rdns, 4'b0011);
        chk("R6 R7 fixed reset", rdfx, 4'b1111);

        put(1'b1, 4'b0101, 2'd0);
        put(1'b0, 4'b0000, 2'd0);
        chk("R4 main legal write", rd, 4'b0101);
        chk("R2 rv32 ignores write", rd32, 4'b0000);
        chk("R2 rv32 user width", eff32, 2'd1);
        chk("R3 nos S ignores write, U updated", rdns, 4'b0001);
        chk("R6 R7 fixed ignores write", rdfx, 4'b1111);
        chk("R7 fixed user width follows S", efffx, 2'd3);

        put(1'b1, 4'b1110, 2'd1);
        put(1'b0, 4'b0000, 2'd1);
        chk("R5 main S=3 rejected, U=2 taken", rd, 4'b0110);
        chk("R3 nos U=2 taken", rdns, 4'b0010);
        chk("R8 nos absent S uses M width", effns, 2'd3);
        chk("R2 rv32 supervisor width", eff32, 2'd1);

        put(1'b0, 4'b0000, 2'd0);
        chk("R8 nos user width", effns, 2'd2);

        put(1'b1, 4'b0000, 2'd3);
        put(1'b0, 4'b0000, 2'd3);
        chk("R5 main zero write ignored", rd, 4'b0110);
        chk("R8 fixed machine width", efffx, 2'd3);
        chk("R2 rv32 machine width", eff32, 2'd1);

        finish_run();
    end

endmodule